// File: doc/BRIEF.md
# Programmable Interval Timer with Snapshot

This block is a down-counting interval timer that software controls through a small synchronous register bus. A 32-bit period value is written as two 16-bit halves, and the counter reloads from it. Once started, the counter counts down to zero. It holds zero for one cycle, then reloads and raises a timeout flag. The level interrupt output goes high when the timeout flag and the interrupt enable are both set.

In continuous mode the counter keeps running after each timeout. In one-shot mode it stops after the first timeout. Software can read the live count without stopping the timer: any write to either snapshot register latches the count into a holding register.

Two build-time options change the behaviour:
- With start/stop control configured out, the counter runs freely from reset.
- With the period fixed, a period write only restarts the count from the build-time timeout.

Top module: `interval_tmr`

Register word addresses:

| Address | Register | Contents |
|---|---|---|
| 0 | status | bit 0 TO = timeout flag; bit 1 RUN = counter is running |
| 1 | control | bit 0 ITO = interrupt enable; bit 1 CONT = continuous mode; bit 2 START; bit 3 STOP |
| 2 | period low | bits 15:0 of the period |
| 3 | period high | bits 31:16 of the period |
| 4 | snapshot low | bits 15:0 of the captured count |
| 5 | snapshot high | bits 31:16 of the captured count |

START and STOP are write-one pulses and always read as 0.

## Requirements
- R1: After reset the following hold:
  - the counter is stopped and loaded with the build-time default period;
  - status and control read 0;
  - the period registers read the default;
  - irq is low.
- R2: The period is split across two 16-bit registers: the low half at address 2 and the high half at address 3. Each reads back the value last written to it.
- R3: With start/stop control present, a write to either period register does two things:
  - it reloads the counter from the updated period;
  - it stops the counter, so RUN reads 0.
- R4: While running, the counter decrements once per cycle and holds 0 for one cycle. On the cycle that follows zero, TO sets and the counter reloads from the period. The interval from start to timeout is therefore period + 1 cycles.
- R5: When a timeout occurs:
  - with CONT set, the counter keeps running;
  - with CONT clear, it stops, leaving the reloaded period in the counter and RUN at 0.
- R6: START and STOP act only when written as 1:
  - a control write with bit 2 set starts the counter;
  - a write with bit 3 set stops it;
  - when both bits are set, STOP wins.
- R7: A write of any data to address 4 or 5 copies the count held before that write's clock edge into the snapshot registers. This works whether the counter is running or stopped. Reads of addresses 4 and 5 return the captured value, not the live count.
- R8: Taking a snapshot changes neither the count sequence nor the running state, so the timeout still arrives period + 1 cycles after the start.
- R9: irq is high exactly while TO and ITO are both 1. Either of two writes acknowledges it:
  - any write to the status register, which clears TO;
  - a control write with ITO = 0.
- R10: With start/stop control configured out, the counter runs from reset onward. START and STOP have no effect, and a period write does not stop the counter.
- R11: With the period not writable, a period write ignores its data and restarts the counter from the build-time timeout. The period registers keep reading that timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register word address |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| irq | output | 1 | Level interrupt request |

## Verification
The embedded assertions check several properties on every cycle:
- a period write stops the counter;
- a STOP write halts it;
- a timeout sets TO and reloads from the period;
- a snapshot write leaves the decrement undisturbed;
- the fixed-period variant reloads its build-time value;
- irq only rises after a timeout or an ITO write.

The bench scenarios cover the behaviour that spans many cycles or depends on register contents:
- the period + 1 interval, measured with and without snapshots in flight;
- one-shot versus continuous mode;
- both ways of acknowledging the interrupt;
- snapshot values captured mid-count and while stopped;
- a second instance built without start/stop control and with a fixed period.

// File: rtl/interval_tmr.sv
module interval_tmr #(
  parameter int          REG_W          = 16,
  parameter int unsigned DEFAULT_PERIOD = 49999,
  parameter bit          HAS_STARTSTOP  = 1'b1,
  parameter bit          PERIOD_WRITABLE = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       bus_addr,
  input  logic             bus_we,
  input  logic [REG_W-1:0] bus_wdata,
  output logic [REG_W-1:0] bus_rdata,
  output logic             irq
);
  localparam int CNT_W = 2 * REG_W;
  localparam logic [CNT_W-1:0] DEF = CNT_W'(DEFAULT_PERIOD);
  localparam logic [2:0] A_STAT = 3'd0, A_CTRL = 3'd1, A_PLO = 3'd2,
                         A_PHI  = 3'd3, A_SLO  = 3'd4, A_SHI = 3'd5;

  logic [CNT_W-1:0] cnt, per, snap, per_nxt, load_val;
  logic run, to, ito, cont;

  wire wr_per  = bus_we && (bus_addr == A_PLO || bus_addr == A_PHI);
  wire wr_snap = bus_we && (bus_addr == A_SLO || bus_addr == A_SHI);
  wire wr_stat = bus_we && bus_addr == A_STAT;
  wire wr_ctrl = bus_we && bus_addr == A_CTRL;
  wire hit     = run && cnt == '0;

  assign per_nxt  = (bus_addr == A_PLO) ? {per[CNT_W-1:REG_W], bus_wdata}
                                        : {bus_wdata, per[REG_W-1:0]};
  assign load_val = PERIOD_WRITABLE ? per_nxt : DEF;
  assign irq      = to & ito;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= DEF;
      per  <= DEF;
      snap <= '0;
      run  <= !HAS_STARTSTOP;
      to   <= 1'b0;
      ito  <= 1'b0;
      cont <= 1'b0;
    end else begin
      if (wr_per) begin
        if (PERIOD_WRITABLE) per <= per_nxt;
        cnt <= load_val;
      end else if (run) begin
        cnt <= hit ? per : cnt - 1'b1;
      end

      if (!HAS_STARTSTOP)                               run <= 1'b1;
      else if (wr_per)                                  run <= 1'b0;
      else if (wr_ctrl && (bus_wdata[3] | bus_wdata[2])) run <= !bus_wdata[3];
      else if (hit && !cont)                            run <= 1'b0;

      if (hit)          to <= 1'b1;
      else if (wr_stat) to <= 1'b0;

      if (wr_ctrl) {cont, ito} <= bus_wdata[1:0];
      if (wr_snap) snap <= cnt;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_STAT:  bus_rdata = {{(REG_W-2){1'b0}}, run, to};
      A_CTRL:  bus_rdata = {{(REG_W-2){1'b0}}, cont, ito};
      A_PLO:   bus_rdata = per[REG_W-1:0];
      A_PHI:   bus_rdata = per[CNT_W-1:REG_W];
      A_SLO:   bus_rdata = snap[REG_W-1:0];
      A_SHI:   bus_rdata = snap[CNT_W-1:REG_W];
      default: bus_rdata = '0;
    endcase
  end

  assert_per_wr_stops_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (HAS_STARTSTOP && wr_per) |=> !run);

  assert_stop_halts_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (HAS_STARTSTOP && wr_ctrl && bus_wdata[3] && !wr_per) |=> !run);

  assert_timeout_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt == '0 && !wr_per) |=> (to && cnt == $past(per)));

  assert_snap_no_disturb_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_snap && run && cnt != '0) |=> (cnt == CNT_W'($past(cnt) - 1'b1)));

  assert_fixed_period_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!PERIOD_WRITABLE && wr_per) |=> cnt == DEF);

  assert_free_run_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !HAS_STARTSTOP |-> run);

  assert_irq_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(run && cnt == '0) || $past(wr_ctrl && bus_wdata[0])));
endmodule

// File: tb/interval_tmr_tb_top.sv
module interval_tmr_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic we0 = 1'b0, we1 = 1'b0, rd_v = 1'b0;
  logic [15:0] rdata0, rdata1;
  logic irq0, irq1;
  int checks = 0, failures = 0;
  bit done = 0;

  typedef struct { logic [15:0] exp; logic [15:0] mask; string tag; bit sel; } item_t;
  item_t sb_q[$];

  always #10 clk = ~clk;

  interval_tmr #(.DEFAULT_PERIOD(1234)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we0),
    .bus_wdata(wdata), .bus_rdata(rdata0), .irq(irq0));

  interval_tmr #(.DEFAULT_PERIOD(5), .HAS_STARTSTOP(1'b0), .PERIOD_WRITABLE(1'b0)) dut_fx_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we1),
    .bus_wdata(wdata), .bus_rdata(rdata1), .irq(irq1));

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%0d expected=%0d", tag, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rd_v && sb_q.size() > 0) begin
      item_t it = sb_q.pop_front();
      check(it.tag, (it.sel ? rdata1 : rdata0) & it.mask, it.exp & it.mask);
    end
  end

  task automatic idle();
    @(negedge clk); #1; we0 = 0; we1 = 0; rd_v = 0;
  endtask

  task automatic wr(bit sel, logic [2:0] a, logic [15:0] d);
    @(negedge clk); #1;
    addr = a; wdata = d; rd_v = 0; we0 = !sel; we1 = sel;
  endtask

  task automatic rd(bit sel, logic [2:0] a, logic [15:0] e, string tag, logic [15:0] m = 16'hFFFF);
    item_t it;
    @(negedge clk); #1;
    addr = a; we0 = 0; we1 = 0; rd_v = 1;
    it.exp = e; it.mask = m; it.tag = tag; it.sel = sel;
    sb_q.push_back(it);
  endtask

  task automatic irq_now(string tag, logic e);
    @(negedge clk);
    check(tag, irq0, e);
    #1; we0 = 0; we1 = 0; rd_v = 0;
  endtask

  task automatic wait_irq(inout int n);
    bit seen;
    while (n < 2000) begin
      @(negedge clk);
      seen = irq0;
      #1; we0 = 0; we1 = 0; rd_v = 0;
      if (seen) break;
      n++;
    end
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    irq_now("R1 irq after reset", 1'b0);
    rd(0, 3'd0, 16'd0, "R1 status after reset");
    rd(0, 3'd1, 16'd0, "R1 control after reset");
    rd(0, 3'd2, 16'd1234, "R1 period default");
    wr(0, 3'd4, 16'hBEEF);
    rd(0, 3'd4, 16'd1234, "R1 R7 snapshot of default count");
    rd(0, 3'd0, 16'd0, "R1 still stopped", 16'h0002);
    // R2 period halves
    wr(0, 3'd3, 16'h0003);
    wr(0, 3'd2, 16'h0A0B);
    rd(0, 3'd3, 16'h0003, "R2 period high readback");
    rd(0, 3'd2, 16'h0A0B, "R2 period low readback");
    wr(0, 3'd3, 16'h0000);
    wr(0, 3'd2, 16'd10);
    // R4 interval, continuous
    wr(0, 3'd1, 16'b0111);
    n = 0; wait_irq(n);
    check("R4 R9 interval P=10", n, 11);
    rd(0, 3'd0, 16'd3, "R4 R5 TO set and still running");
    wr(0, 3'd0, 16'h0000);
    irq_now("R9 ack by status write", 1'b0);
    wr(0, 3'd1, 16'b1011);
    rd(0, 3'd0, 16'd0, "R6 stop write halts");
    // R7/R8 snapshot while running
    wr(0, 3'd2, 16'd20);
    wr(0, 3'd1, 16'b0111);
    wr(0, 3'd5, 16'h1234);
    idle(); idle(); idle();
    wr(0, 3'd4, 16'h0000);
    n = 5; wait_irq(n);
    check("R8 interval undisturbed by snapshots", n, 21);
    rd(0, 3'd4, 16'd16, "R7 running snapshot low");
    rd(0, 3'd5, 16'd0, "R7 running snapshot high");
    wr(0, 3'd0, 16'hFFFF);
    // R5 one-shot, R9 ITO ack
    wr(0, 3'd2, 16'd4);
    wr(0, 3'd1, 16'b0101);
    n = 0; wait_irq(n);
    check("R4 interval P=4", n, 5);
    rd(0, 3'd0, 16'd1, "R5 one-shot stopped with TO");
    wr(0, 3'd1, 16'b0000);
    irq_now("R9 ack by clearing ITO", 1'b0);
    rd(0, 3'd0, 16'd1, "R9 TO kept after ITO clear");
    wr(0, 3'd4, 16'd0);
    rd(0, 3'd4, 16'd4, "R5 one-shot reloaded period");
    wr(0, 3'd0, 16'd0);
    // R3 period write stops and reloads
    wr(0, 3'd1, 16'b0110);
    idle(); idle();
    wr(0, 3'd2, 16'd9);
    rd(0, 3'd0, 16'd0, "R3 period write stops counter");
    idle(); idle();
    wr(0, 3'd4, 16'd0);
    rd(0, 3'd4, 16'd9, "R3 R7 stopped count reloaded");
    // R6 start alone, start+stop
    wr(0, 3'd1, 16'b0100);
    rd(0, 3'd0, 16'd2, "R6 start runs");
    wr(0, 3'd1, 16'b1100);
    rd(0, 3'd0, 16'd0, "R6 stop wins over start");
    // R10/R11 fixed, free-running instance
    rd(1, 3'd0, 16'd2, "R10 runs from reset", 16'h0002);
    wr(1, 3'd1, 16'b1000);
    rd(1, 3'd0, 16'd2, "R10 stop ignored", 16'h0002);
    wr(1, 3'd2, 16'd100);
    wr(1, 3'd4, 16'd0);
    rd(1, 3'd4, 16'd5, "R11 period write reloads fixed timeout");
    rd(1, 3'd2, 16'd5, "R11 period register keeps fixed value");
    wr(1, 3'd3, 16'd7);
    idle(); idle();
    wr(1, 3'd4, 16'd0);
    rd(1, 3'd4, 16'd3, "R10 period write does not stop count");
    rd(1, 3'd0, 16'd2, "R10 still running", 16'h0002);
    idle(); idle();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule